// File: doc/BRIEF.md
# Triggered Capture and Slowed Replay

This block watches a parallel bank of logic probe lines, waits for a hardware trigger condition, and then records a fixed-length burst of consecutive samples into an on-chip buffer, one sample per system clock. When the buffer is full it plays the stored samples back on its output at a greatly reduced rate. A downstream sound generator can turn each channel into a tone, so that a listener hears the captured activity in time order.

Each probe channel has two select bits. A trigger select adds the channel to a set that must all be high together before capture starts. A veto select lets a high level on that channel block the start. A select bit at 0 has no effect on either rule, so unused selects are tied low. A programmable 20-bit divider sets how many clocks each replayed sample lasts. At the largest setting one captured clock lasts about a million clocks. Replay can stop after the last sample or wrap around and repeat without end. An arm pulse at any time restarts the whole sequence.

Top module: `slow_capture_replay`

## Requirements
- R1: After synchronous reset `play_out` is 0, and `busy` and `done` are both 0.
- R2: On the clock after an `arm` pulse, `busy` is 1, `done` is 0, `play_out` is 0, and the block waits for the trigger. This applies in every state.
- R3: Probes are registered once, and the trigger rule is evaluated on the registered sample. Capture starts on the first registered sample in which every channel whose `trig_sel` bit is 1 is high. That sample becomes stored sample 0.
- R4: A registered sample in which any channel whose `veto_sel` bit is 1 is high never starts a capture, even when the trigger rule is met.
- R5: A select bit at 0 is inactive. With `trig_sel` all 0, capture starts on the first registered sample after arming in which no vetoing channel is high.
- R6: Capture stores DEPTH consecutive registered samples (1024 by default), one per clock, starting with the trigger sample. Replay then starts by itself on the next clock.
- R7: In replay, stored sample k appears on `play_out` exactly (k+1)*(`rate_div`+1) clocks after replay begins. Between these updates `play_out` does not change.
- R8: With `loop_en` at 0, after the last sample is shown `done` becomes 1 and `busy` becomes 0 on the same clock, and `play_out` holds the last sample. `busy` and `done` are never 1 together.
- R9: With `loop_en` at 1, sample 0 follows the last sample at the same spacing, and replay continues with `busy` at 1 until the next `arm`.
- R10: An `arm` pulse during replay aborts it. `play_out` clears to 0, and no new capture starts until the trigger rule is met again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the capture sample clock |
| rst | input | 1 | Synchronous active-high reset |
| probe_in | input | CH_W | Logic probe channels |
| trig_sel | input | CH_W | Per-channel trigger select; 1 puts the channel in the all-high set |
| veto_sel | input | CH_W | Per-channel veto select; 1 lets the channel block the start |
| loop_en | input | 1 | 1 repeats the replay without end |
| arm | input | 1 | One-clock pulse that (re)starts waiting for the trigger |
| rate_div | input | DIV_W | Replay spacing; each sample lasts rate_div+1 clocks |
| play_out | output | CH_W | Slowed replay of the stored channel states |
| busy | output | 1 | Armed, capturing or replaying |
| done | output | 1 | A replay without looping has finished |

## Verification
Some properties are checked on every cycle by the assertions. The arm pulse must restart the block. A vetoing or incomplete sample must not leave the waiting state. The output must not move between divider ticks. Looped replay must not leave replay, and the two flags must never be 1 together. Other behaviour can only be shown through the bench's scenarios, checked against its reference model. These cover which exact sample becomes stored sample 0, the exact spacing of replayed values, the sample order after a wrap, and the output value left behind after a finished replay or an abort.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ARM,
    S_CAP,
    S_REP,
    S_DONE
  } cr_state_e;
endpackage

// File: rtl/cr_trigger.sv
module cr_trigger #(
  parameter int CH_W = 8
) (
  input  logic [CH_W-1:0] sample,
  input  logic [CH_W-1:0] trig_sel,
  input  logic [CH_W-1:0] veto_sel,
  output logic            fire
);
  logic [CH_W-1:0] lane_ok;
  logic [CH_W-1:0] lane_veto;

  // per channel: unselected lanes always agree; selected veto lanes object when high
  for (genvar g = 0; g < CH_W; g++) begin : g_lane
    assign lane_ok[g]   = ~trig_sel[g] | sample[g];
    assign lane_veto[g] = veto_sel[g] & sample[g];
  end

  assign fire = (&lane_ok) & ~(|lane_veto);
endmodule

// File: rtl/cr_rate_div.sv
module cr_rate_div #(
  parameter int DIV_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cr_sample_ram.sv
module cr_sample_ram #(
  parameter int CH_W   = 8,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [CH_W-1:0]   wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [CH_W-1:0]   rdata
);
  logic [CH_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // registered read port with synchronous clear, as a block RAM output latch offers
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/slow_capture_replay.sv
module slow_capture_replay #(
  parameter int CH_W  = 8,
  parameter int DEPTH = 1024,
  parameter int DIV_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CH_W-1:0]  probe_in,
  input  logic [CH_W-1:0]  trig_sel,
  input  logic [CH_W-1:0]  veto_sel,
  input  logic             loop_en,
  input  logic             arm,
  input  logic [DIV_W-1:0] rate_div,
  output logic [CH_W-1:0]  play_out,
  output logic             busy,
  output logic             done
);
  import cr_pkg::*;

  localparam int ADDR_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  cr_state_e         state_q, state_n;
  logic [CH_W-1:0]   probe_q;
  logic [ADDR_W-1:0] wptr_q, rptr_q;
  logic              fire, tick, we, re;

  cr_trigger #(.CH_W(CH_W)) u_trig (
    .sample  (probe_q),
    .trig_sel(trig_sel),
    .veto_sel(veto_sel),
    .fire    (fire)
  );

  cr_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (state_q == S_REP),
    .limit(rate_div),
    .tick (tick)
  );

  cr_sample_ram #(.CH_W(CH_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk  (clk),
    .rst  (rst),
    .clr  (arm),
    .we   (we),
    .waddr(wptr_q),
    .wdata(probe_q),
    .re   (re),
    .raddr(rptr_q),
    .rdata(play_out)
  );

  always_comb begin
    state_n = state_q;
    we      = 1'b0;
    re      = 1'b0;
    if (arm) begin
      state_n = S_ARM;
    end else begin
      case (state_q)
        S_ARM: begin
          if (fire) begin
            we      = 1'b1;
            state_n = S_CAP;
          end
        end
        S_CAP: begin
          we = 1'b1;
          if (wptr_q == LAST) state_n = S_REP;
        end
        S_REP: begin
          re = tick;
          if (tick && rptr_q == LAST && !loop_en) state_n = S_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      probe_q <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      probe_q <= probe_in;
      state_q <= state_n;
      busy    <= (state_n == S_ARM) || (state_n == S_CAP) || (state_n == S_REP);
      done    <= (state_n == S_DONE);
      if (arm) begin
        wptr_q <= '0;
        rptr_q <= '0;
      end else begin
        if (we) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
        if (re) rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      end
    end
  end

  assert_arm_restarts_R2: assert property (@(posedge clk) disable iff (rst)
    arm |=> (state_q == S_ARM && busy && !done && play_out == '0));

  assert_all_trig_high_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ARM && !arm && ((probe_q & trig_sel) != trig_sel)) |=> state_q == S_ARM);

  assert_veto_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ARM && !arm && |(probe_q & veto_sel)) |=> state_q == S_ARM);

  assert_hold_between_ticks_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_REP && !tick && !arm) |=> $stable(play_out));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  assert_loop_keeps_playing_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_REP && loop_en && !arm) |=> (state_q == S_REP && busy));
endmodule

// File: tb/test_slow_capture_replay.sv
module test_slow_capture_replay;
  localparam int CH_W  = 8;
  localparam int DEPTH = 1024;
  localparam int DIV_W = 20;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CH_W-1:0]  probe_in = '0;
  logic [CH_W-1:0]  trig_sel = '0;
  logic [CH_W-1:0]  veto_sel = '0;
  logic             loop_en = 1'b0;
  logic             arm = 1'b0;
  logic [DIV_W-1:0] rate_div = '0;
  logic [CH_W-1:0]  play_out;
  logic             busy, done;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit started = 0;

  always #4 clk = ~clk;

  slow_capture_replay #(.CH_W(CH_W), .DEPTH(DEPTH), .DIV_W(DIV_W)) i_slow_capture_replay (
    .clk(clk), .rst(rst), .probe_in(probe_in), .trig_sel(trig_sel), .veto_sel(veto_sel),
    .loop_en(loop_en), .arm(arm), .rate_div(rate_div),
    .play_out(play_out), .busy(busy), .done(done)
  );

  // behavioural reference: 0 idle, 1 waiting, 2 recording, 3 replaying, 4 finished
  int             m_st = 0;
  logic [CH_W-1:0] m_prev = '0;
  logic [CH_W-1:0] m_rec[$];
  int             m_cnt = 0;
  int             m_idx = 0;
  logic [CH_W-1:0] m_out = '0;

  function automatic bit m_hit(logic [CH_W-1:0] s);
    return ((s & trig_sel) == trig_sel) && ((s & veto_sel) == '0);
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_st = 0; m_prev = '0; m_rec.delete(); m_cnt = 0; m_idx = 0; m_out = '0;
    end else begin
      if (arm) begin
        m_st = 1; m_rec.delete(); m_out = '0;
      end else begin
        case (m_st)
          1: if (m_hit(m_prev)) begin m_rec.push_back(m_prev); m_st = 2; end
          2: begin
            m_rec.push_back(m_prev);
            if (m_rec.size() == DEPTH) begin m_st = 3; m_cnt = 0; m_idx = 0; end
          end
          3: begin
            if (m_cnt == int'(rate_div)) begin
              m_cnt = 0;
              m_out = m_rec[m_idx];
              if (m_idx == DEPTH - 1) begin
                if (loop_en) m_idx = 0; else m_st = 4;
              end else m_idx++;
            end else m_cnt++;
          end
          default: ;
        endcase
      end
      m_prev = probe_in;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string m_tag();
    case (m_st)
      1: return "R3";
      2: return "R6";
      3: return loop_en ? "R9" : "R7";
      4: return "R8";
      default: return "R1";
    endcase
  endfunction

  always @(negedge clk) begin
    if (started && !finished) begin
      check(m_tag(), 32'(play_out), 32'(m_out), "play_out vs model");
      check(m_tag(), 32'(busy), 32'(m_st >= 1 && m_st <= 3), "busy vs model");
      check(m_tag(), 32'(done), 32'(m_st == 4), "done vs model");
    end
  end

  task automatic end_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    end_run();
  end

  function automatic logic [CH_W-1:0] pat(int i);
    return CH_W'(i * 29 + 7) | 8'h10;
  endfunction

  initial begin
    repeat (5) @(negedge clk);
    check("R1", 32'(play_out), 0, "play_out in reset");
    check("R1", 32'(busy), 0, "busy in reset");
    check("R1", 32'(done), 0, "done in reset");
    rst = 1'b0;
    @(negedge clk);

    // scenario A: two-channel trigger with a veto channel, single replay, spacing 4
    trig_sel = 8'h05; veto_sel = 8'h80; rate_div = 3; loop_en = 0;
    probe_in = 8'h85; arm = 1;
    @(negedge clk); arm = 0;
    check("R2", 32'(busy), 1, "busy after arm");
    check("R2", 32'(done), 0, "done after arm");
    repeat (4) @(negedge clk);
    probe_in = 8'h01;                         // only one trigger channel high
    repeat (4) @(negedge clk);
    probe_in = 8'h05;
    @(negedge clk);
    for (int i = 0; i < 6000 && play_out === '0; i++) begin
      probe_in = pat(i);
      @(negedge clk);
    end
    check("R4", 32'(play_out), 32'h05, "first replayed sample not the vetoed one");
    check("R6", 32'(play_out), 32'h05, "sample 0 is the trigger sample");
    for (int i = 0; i < 6000 && !done; i++) @(negedge clk);
    check("R8", 32'(done), 1, "done after single replay");
    check("R8", 32'(busy), 0, "busy after single replay");
    check("R8", 32'(play_out), 32'(m_rec[DEPTH-1]), "last sample held");
    repeat (3) @(negedge clk);
    check("R8", 32'(play_out), 32'(m_rec[DEPTH-1]), "last sample still held");

    // scenario B: empty trigger set, veto on channel 1, looped replay at full speed
    trig_sel = 8'h00; veto_sel = 8'h02; rate_div = 0; loop_en = 1;
    probe_in = 8'h02; arm = 1;
    @(negedge clk); arm = 0;
    repeat (3) @(negedge clk);
    probe_in = 8'h3C;
    @(negedge clk);
    for (int i = 0; i < 3000 && play_out === '0; i++) begin
      probe_in = pat(i + 100);
      @(negedge clk);
    end
    check("R5", 32'(play_out), 32'h3C, "empty trigger set starts on first unvetoed sample");
    repeat (2600) @(negedge clk);
    check("R9", 32'(busy), 1, "still busy after wraps");
    check("R9", 32'(done), 0, "no done while looping");

    // scenario C: abort the looping replay and wait for channel 7
    trig_sel = 8'h80; veto_sel = 8'h00; probe_in = 8'h00; arm = 1;
    @(negedge clk); arm = 0;
    check("R10", 32'(play_out), 0, "output cleared by abort");
    check("R10", 32'(busy), 1, "busy after abort");
    repeat (20) @(negedge clk);
    check("R10", 32'(play_out), 0, "no capture without trigger");
    check("R10", 32'(done), 0, "no done while waiting");
    end_run();
  end
endmodule